// File: doc/BRIEF.md
# Serial EEPROM Page Programming Controller

This block is the programming back end of a small on-chip EEPROM that sits behind a serial programming port. The serial framing and instruction decoding happen elsewhere. This block receives a decoded command, with its address and data, on a single strobe. It returns read data in a register that the shifter sends out.

The block offers two ways to program. The first is a direct byte write that programs one location. The second is page programming: a four-slot page buffer is filled one byte at a time, and a commit then programs only the slots that were filled. Each programmed location is erased to all ones first and then written. A write-delay timer holds a busy indication for a fixed number of clock cycles, derived from the clock frequency and the required minimum delay. While busy is high, the block refuses programming commands and flags them. Reads are served at any time. Before the delay ends they return the old contents.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, and busy, cmd_err and rd_data are all 0.
- R2: A byte write (cmd_op = 1) programs the full 8-bit cmd_addr with cmd_data. Erase comes first, so the stored result equals cmd_data whatever the previous contents were, including bits that go from 0 to 1.
- R3: A page load (cmd_op = 2) stores cmd_data in the buffer slot selected by cmd_addr[1:0] and marks that slot as filled. It does not start the delay timer and does not change the array.
- R4: A commit (cmd_op = 3) selects the page with cmd_addr[7:2]. Each filled slot s is written to address {page, s}. The unfilled slots of that page keep their contents.
- R5: When a commit completes, all filled marks are cleared. A later commit with no new loads leaves the array unchanged.
- R6: A read (cmd_op = 4) places the byte stored at cmd_addr on rd_data one cycle later. rd_data holds that value until the next read.
- R7: An accepted byte write or commit raises busy in the next cycle. busy stays high for exactly WAIT_CYC cycles, where WAIT_CYC = ceil(CLK_KHZ*WAIT_US/1000).
- R8: The array changes at the edge where busy falls. A read issued while busy is high returns the old byte.
- R9: A byte write, load or commit presented while busy is high is ignored, and cmd_err is high for the one following cycle.
- R10: Opcodes 0, 5, 6 and 7, or any command with cmd_valid low, change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 1 byte write, 2 load, 3 commit, 4 read |
| cmd_addr | input | 8 | Byte address: [7:2] page, [1:0] slot |
| cmd_data | input | 8 | Write or load data |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Write delay in progress |
| cmd_err | output | 1 | One-cycle flag for a refused programming command |

## Verification
The properties assume that cmd_op is always a defined value and that a programming command needs an idle cycle before it is accepted. They also assume that a busy run is never extended by a command. The stimulus drives every input at the falling edge and holds it through one rising edge. It includes deliberate writes, loads and commits during busy, so the refusal path is exercised and the timer is never restarted by those commands. Random opcodes also cover the unused codes and strobes with cmd_valid low. A bench model of the array, page buffer and timer follows every edge.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_BYTE_WR = 3'd1,
    OP_LOAD    = 3'd2,
    OP_COMMIT  = 3'd3,
    OP_READ    = 3'd4
  } eep_op_e;
endpackage

// File: rtl/eep_wait_timer.sv
module eep_wait_timer #(
  parameter int unsigned WAIT_CYC = 72000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else if (start)
      cnt_d = CNT_W'(WAIT_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer #(
  parameter int unsigned SLOT_BITS = 2,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned SLOTS    = 1 << SLOT_BITS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_en,
  input  logic [SLOT_BITS-1:0]           load_slot,
  input  logic [DATA_W-1:0]              load_data,
  input  logic                           clear,
  output logic [SLOTS-1:0][DATA_W-1:0]   slot_data,
  output logic [SLOTS-1:0]               slot_full
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] data_q, data_d;
    logic              full_q, full_d;

    assign hit = load_en && (load_slot == SLOT_BITS'(s));

    always_comb begin
      data_d = data_q;
      full_d = full_q;
      if (hit) begin
        data_d = load_data;
        full_d = 1'b1;
      end else if (clear) begin
        full_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        full_q <= 1'b0;
      end else begin
        data_q <= data_d;
        full_q <= full_d;
      end
    end

    assign slot_data[s] = data_q;
    assign slot_full[s] = full_q;
  end
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SLOT_BITS = 2,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned SLOTS    = 1 << SLOT_BITS,
  localparam int unsigned PAGE_W   = ADDR_W - SLOT_BITS,
  localparam int unsigned PAGES    = 1 << PAGE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PAGE_W-1:0]            wr_page,
  input  logic [SLOTS-1:0]             wr_mask,
  input  logic [SLOTS-1:0][DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_byte
);
  logic [DATA_W-1:0] cells [PAGES*SLOTS];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    for (genvar s = 0; s < SLOTS; s++) begin : g_cell
      logic              sel;
      logic [DATA_W-1:0] erased, cell_q, cell_d;

      assign sel = wr_en && (wr_page == PAGE_W'(p)) && wr_mask[s];

      // Program step after erase: erase drives all bits high, writing clears
      // the bits that are zero in the data.
      always_comb begin
        erased = '1;
        cell_d = cell_q;
        if (sel) cell_d = erased & wr_data[s];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '1;
        else        cell_q <= cell_d;
      end

      assign cells[p*SLOTS + s] = cell_q;
    end
  end

  assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 16000,
  parameter int unsigned WAIT_US   = 4500,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SLOT_BITS = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              cmd_err
);
  localparam int unsigned SLOTS    = 1 << SLOT_BITS;
  localparam int unsigned PAGE_W   = ADDR_W - SLOT_BITS;
  localparam int unsigned WAIT_CYC = (CLK_KHZ * WAIT_US + 999) / 1000;

  eep_op_e op;
  assign op = eep_op_e'(cmd_op);

  logic is_byte, is_load, is_commit, is_read, is_prog_type;
  assign is_byte      = cmd_valid && (op == OP_BYTE_WR);
  assign is_load      = cmd_valid && (op == OP_LOAD);
  assign is_commit    = cmd_valid && (op == OP_COMMIT);
  assign is_read      = cmd_valid && (op == OP_READ);
  assign is_prog_type = is_byte || is_load || is_commit;

  logic tmr_busy, tmr_done, start, load_en;
  assign start   = !tmr_busy && (is_byte || is_commit);
  assign load_en = !tmr_busy && is_load;

  // Pending program operation, applied when the delay expires
  logic [PAGE_W-1:0]            pend_page_q, pend_page_d;
  logic [SLOTS-1:0]             pend_mask_q, pend_mask_d;
  logic [SLOTS-1:0][DATA_W-1:0] pend_data_q, pend_data_d;
  logic                         pend_commit_q, pend_commit_d;
  logic [DATA_W-1:0]            rd_q, rd_d;
  logic                         err_q, err_d;

  logic [SLOTS-1:0][DATA_W-1:0] buf_data;
  logic [SLOTS-1:0]             buf_full;
  logic [DATA_W-1:0]            arr_byte;

  eep_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  eep_page_buffer #(.SLOT_BITS(SLOT_BITS), .DATA_W(DATA_W)) u_pbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_slot (cmd_addr[SLOT_BITS-1:0]),
    .load_data (cmd_data),
    .clear     (tmr_done && pend_commit_q),
    .slot_data (buf_data),
    .slot_full (buf_full)
  );

  eep_cell_array #(.ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tmr_done),
    .wr_page (pend_page_q),
    .wr_mask (pend_mask_q),
    .wr_data (pend_data_q),
    .rd_addr (cmd_addr),
    .rd_byte (arr_byte)
  );

  always_comb begin
    pend_page_d   = pend_page_q;
    pend_mask_d   = pend_mask_q;
    pend_data_d   = pend_data_q;
    pend_commit_d = pend_commit_q;
    if (start) begin
      pend_page_d   = cmd_addr[ADDR_W-1:SLOT_BITS];
      pend_commit_d = is_commit;
      if (is_commit) begin
        pend_mask_d = buf_full;
        pend_data_d = buf_data;
      end else begin
        pend_mask_d = '0;
        pend_mask_d[cmd_addr[SLOT_BITS-1:0]] = 1'b1;
        for (int s = 0; s < SLOTS; s++) pend_data_d[s] = cmd_data;
      end
    end
  end

  always_comb begin
    rd_d  = is_read ? arr_byte : rd_q;
    err_d = tmr_busy && is_prog_type;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_page_q   <= '0;
      pend_mask_q   <= '0;
      pend_data_q   <= '0;
      pend_commit_q <= 1'b0;
      rd_q          <= '0;
      err_q         <= 1'b0;
    end else begin
      pend_page_q   <= pend_page_d;
      pend_mask_q   <= pend_mask_d;
      pend_data_q   <= pend_data_d;
      pend_commit_q <= pend_commit_d;
      rd_q          <= rd_d;
      err_q         <= err_d;
    end
  end

  assign rd_data = rd_q;
  assign busy    = tmr_busy;
  assign cmd_err = err_q;
endmodule

// File: rtl/eep_prog_checker.sv
module eep_prog_checker #(
  parameter int unsigned CLK_KHZ = 16000,
  parameter int unsigned WAIT_US = 4500,
  parameter int unsigned DATA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              cmd_err
);
  localparam int unsigned WAIT_CYC = (CLK_KHZ * WAIT_US + 999) / 1000;
  localparam int unsigned RUN_W    = $clog2(WAIT_CYC + 2);

  logic prog_cmd, start_cmd, read_cmd;
  assign prog_cmd  = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3);
  assign start_cmd = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd3);
  assign read_cmd  = cmd_valid && (cmd_op == 3'd4);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(WAIT_CYC))); // R7
  AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_q != '0) |-> (run_q == RUN_W'(WAIT_CYC))); // R7
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_cmd) |=> busy); // R7
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_cmd) |=> !busy); // R10
  AST_ERR_ONLY_WHEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($past(busy) && $past(prog_cmd))); // R9
  AST_REFUSAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_cmd) |=> cmd_err); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !read_cmd |=> $stable(rd_data)); // R6
endmodule

bind eeprom_prog_ctrl eep_prog_checker #(
  .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .DATA_W(DATA_W)
) u_eep_prog_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_data(rd_data), .busy(busy), .cmd_err(cmd_err)
);

// File: tb/test_eeprom_prog_ctrl.sv
module test_eeprom_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ  = 1000;
  localparam int US   = 12;
  localparam int WAIT = (KHZ * US + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_addr, cmd_data;
  logic [7:0] rd_data;
  logic       busy, cmd_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_prog_ctrl #(.CLK_KHZ(KHZ), .WAIT_US(US)) i_eeprom_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_data(rd_data),
    .busy(busy), .cmd_err(cmd_err)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // Bench model
  logic [7:0] mem_m [256];
  logic [7:0] buf_m [4];
  bit         full_m [4];
  int         cnt_m;
  int         p_page;
  bit         p_mask [4];
  logic [7:0] p_data [4];
  bit         p_commit;
  logic [7:0] rd_m;
  bit         err_m;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_apply();
    for (int s = 0; s < 4; s++)
      if (p_mask[s]) mem_m[p_page*4 + s] = p_data[s];
    if (p_commit) for (int s = 0; s < 4; s++) full_m[s] = 0;
  endfunction

  function automatic void model_edge(input bit v, input logic [2:0] op,
                                     input logic [7:0] a, input logic [7:0] d);
    int pre = cnt_m;
    bit wtype = v && (op == 3'd1 || op == 3'd2 || op == 3'd3);
    err_m = 0;
    if (v && op == 3'd4) rd_m = mem_m[a];
    if (pre != 0) begin
      if (wtype) err_m = 1;
      if (pre == 1) model_apply();
      cnt_m = pre - 1;
    end else if (v) begin
      case (op)
        3'd1: begin
          p_page = int'(a[7:2]); p_commit = 0;
          for (int s = 0; s < 4; s++) begin p_mask[s] = (s == int'(a[1:0])); p_data[s] = d; end
          cnt_m = WAIT;
        end
        3'd2: begin buf_m[a[1:0]] = d; full_m[a[1:0]] = 1; end
        3'd3: begin
          p_page = int'(a[7:2]); p_commit = 1;
          for (int s = 0; s < 4; s++) begin p_mask[s] = full_m[s]; p_data[s] = buf_m[s]; end
          cnt_m = WAIT;
        end
        default: ;
      endcase
    end
  endfunction

  task automatic step(input bit v, input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_data = d;
    model_edge(v, op, a, d);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check("R7 busy", {7'd0, busy}, {7'd0, cnt_m != 0});
    check("R9 cmd_err", {7'd0, cmd_err}, {7'd0, err_m});
    check("R6 rd_data", rd_data, rd_m);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'd0, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int busy_len;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    for (int s = 0; s < 4; s++) begin buf_m[s] = 0; full_m[s] = 0; p_mask[s] = 0; p_data[s] = 0; end
    cnt_m = 0; p_page = 0; p_commit = 0; rd_m = 0; err_m = 0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 cmd_err", {7'd0, cmd_err}, 8'd0);
    check("R1 rd_data", rd_data, 8'd0);
    step(1, 3'd4, 8'h00, 0); check("R1 erased 0x00", rd_data, 8'hFF);
    step(1, 3'd4, 8'hFF, 0); check("R1 erased 0xFF", rd_data, 8'hFF);

    // R2/R8 byte write, old data during busy
    step(1, 3'd1, 8'h13, 8'h5A);
    step(1, 3'd4, 8'h13, 0); check("R8 old data while busy", rd_data, 8'hFF);
    idle(WAIT);
    step(1, 3'd4, 8'h13, 0); check("R2 byte write", rd_data, 8'h5A);
    step(1, 3'd1, 8'h13, 8'hA5);
    idle(WAIT);
    step(1, 3'd4, 8'h13, 0); check("R2 erase before write", rd_data, 8'hA5);

    // R7 busy length
    step(1, 3'd1, 8'h40, 8'h00);
    busy_len = 0;
    while (busy && busy_len < 4 * WAIT) begin busy_len++; idle(1); end
    check("R7 busy length", 8'(busy_len), 8'(WAIT));

    // R9 refused load and commit while busy
    step(1, 3'd1, 8'h20, 8'h00);
    step(1, 3'd2, 8'h21, 8'h77); check("R9 load refused", {7'd0, cmd_err}, 8'd1);
    step(1, 3'd3, 8'h20, 8'h00); check("R9 commit refused", {7'd0, cmd_err}, 8'd1);
    idle(WAIT);

    // R3/R4 page load and commit
    step(1, 3'd2, 8'h00, 8'h11); check("R3 load no busy", {7'd0, busy}, 8'd0);
    step(1, 3'd2, 8'h02, 8'h33);
    step(1, 3'd4, 8'h14, 0); check("R3 load leaves array", rd_data, 8'hFF);
    step(1, 3'd3, 8'h14, 8'h00);
    idle(WAIT);
    step(1, 3'd4, 8'h14, 0); check("R4 slot0 written", rd_data, 8'h11);
    step(1, 3'd4, 8'h15, 0); check("R4 slot1 kept", rd_data, 8'hFF);
    step(1, 3'd4, 8'h16, 0); check("R4 slot2 written", rd_data, 8'h33);
    step(1, 3'd4, 8'h17, 0); check("R4 slot3 kept", rd_data, 8'hFF);

    // R5 flags cleared after commit
    step(1, 3'd1, 8'h18, 8'h42);
    idle(WAIT);
    step(1, 3'd3, 8'h18, 8'h00);
    idle(WAIT);
    step(1, 3'd4, 8'h18, 0); check("R5 empty commit no change", rd_data, 8'h42);

    // R10 unused opcodes and invalid strobe
    step(1, 3'd5, 8'h13, 8'h00); check("R10 op5 no busy", {7'd0, busy}, 8'd0);
    step(1, 3'd7, 8'h13, 8'h00); check("R10 op7 no error", {7'd0, cmd_err}, 8'd0);
    step(0, 3'd1, 8'h13, 8'h00); check("R10 valid low no busy", {7'd0, busy}, 8'd0);
    step(1, 3'd4, 8'h13, 0); check("R10 data kept", rd_data, 8'hA5);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 8) != 0;
      logic [2:0] op = 3'($urandom % 8);
      logic [7:0] a  = ($urandom % 4 == 0) ? 8'(8'h10 + $urandom % 16) : 8'($urandom);
      step(v, op, a, 8'($urandom));
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule